// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block sits on the path of bus requests aimed at a graphics aperture and turns addresses that fall inside the aperture window into physical addresses. The mapping lives in memory as a two-level structure. A directory of 4-byte entries is indexed by which 4 MiB slice of the window the address falls in. Each valid directory entry points to a 4 KiB table of 1024 page entries, one for each 4 KiB page of that slice. Addresses outside the window, and all addresses while translation is off, pass through unchanged.

Software sets the block up through a small byte-addressed register port: the directory base, the aperture base, the window size and the enables. A write to a flush register drops every cached translation at once, which software does after it edits the tables. Completed translations are kept in a small fully associative cache tagged by virtual page number. A request that misses the cache starts a walk over a single-outstanding memory read port. Only one lookup is in flight at a time, and the request port is back-pressured until it returns.

Top module: `apt_xlate_top`

## Requirements
- R1: Register offsets: 0x02 is a 16-bit control register whose bit 2 enables translation. 0x04 is the directory base, of which bits 31:12 are kept. 0x08 is the window size register, with bit 0 as window enable and bits 3:1 as size code; only bits 3:0 are kept. 0x0C is the flush register, which reads as 0. 0x10 is the aperture base, of which bits 31:22 are kept. Reads return the kept bits and zeros elsewhere, and all registers reset to 0.
- R2: Translation is active only when control bit 2 and size register bit 0 are both set. Otherwise every request is answered in the cycle after acceptance with hit 0, error 0 and the request address unchanged, and no memory read is made.
- R3: The size code k = bits 3:1 selects a window of 32 MiB shifted left by k, for k = 0 to 6 (register codes 0x0, 0x2 … 0xC, giving 32 to 2048 MiB). A code of k = 7 closes the window. An address below the aperture base, or at or above base plus window size, passes through as in R2.
- R4: On a miss, the first read is made at directory base + 4 × (address[31:22] − aperture base[31:22]). The second read is made at {directory entry[31:12], address[21:12], 2'b00}. The result is {table entry[31:12], address[11:0]} with hit 1 and error 0. All read addresses are word aligned.
- R5: Bit 0 of a directory or table entry marks it valid. If either entry in a walk is invalid, the response has error 1, hit 1 and address 0, and no walk continues past an invalid directory entry. Nothing is cached, so a repeat of the same page walks again.
- R6: A request whose page is cached is answered in the cycle after acceptance with the cached translation, and no memory read is made.
- R7: The cache holds 8 entries filled round-robin from slot 0 after reset or flush. The ninth distinct page installed replaces the oldest one.
- R8: A write to the flush register with data bit 0 set invalidates every cached entry, including for a request accepted in the same cycle. A write with bit 0 clear has no effect.
- R9: A flush during a walk abandons it. Any read already issued is drained and its data discarded, then the walk restarts from the directory. The response reflects table contents read after the flush, and the abandoned result is never installed.
- R10: req_ready is high only while no walk is in progress. It is high after reset, and no memory read is issued while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset (read and write) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Address was inside an active window |
| rsp_err | output | 1 | A table entry on the walk was invalid |
| rsp_addr | output | 32 | Translated or passed-through address |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | 32 | Table read address |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 32 | Table read data |

## Verification
The bound checker verifies the following on every cycle:
- a pass-through request returns its own address next cycle with hit low;
- error responses carry hit 1 and a zero address;
- a flush leaves no valid entry;
- an install never coincides with a flush and only follows a valid table entry;
- the fill pointer advances by one slot per install;
- reads are word aligned and only issued while the request port is stalled.

Only the directed scenarios can show the following, because each needs a reference walk over the bench's own table image:
- the exact directory and table read addresses and the translated result;
- window edges under several size codes;
- the eviction order after nine pages;
- that a flush during a walk makes the response reflect table contents changed after the flush.

// File: rtl/apt_pkg.sv
package apt_pkg;
  localparam int AW      = 32;
  localparam int PG_SH   = 12;
  localparam int SLC_SH  = 22;
  localparam int VPN_W   = AW - PG_SH;
  localparam int SLC_W   = AW - SLC_SH;
  localparam int TIX_W   = SLC_SH - PG_SH;
  localparam int MIN_SH  = 25;

  localparam logic [7:0] OFS_CTL   = 8'h02;
  localparam logic [7:0] OFS_DBASE = 8'h04;
  localparam logic [7:0] OFS_SIZE  = 8'h08;
  localparam logic [7:0] OFS_FLUSH = 8'h0C;
  localparam logic [7:0] OFS_ABASE = 8'h10;
  localparam int CTL_EN_BIT = 2;

  typedef enum logic [2:0] {
    W_IDLE, W_DIR_REQ, W_DIR_WAIT, W_PTE_REQ, W_PTE_WAIT, W_DRAIN
  } walk_st_t;

  function automatic logic f_in_window(input logic [AW-1:0] addr,
                                       input logic [AW-1:0] base,
                                       input logic [2:0] code);
    logic [AW:0] off;
    logic [5:0]  sh;
    off = {1'b0, addr} - {1'b0, base};
    sh  = 6'(MIN_SH) + {3'b000, code};
    if (code == 3'd7) return 1'b0;
    return !off[AW] && ((off[AW-1:0] >> sh) == '0);
  endfunction

  function automatic logic [AW-1:0] f_dir_addr(input logic [AW-1:0] dbase,
                                               input logic [AW-1:0] addr,
                                               input logic [AW-1:0] base);
    logic [SLC_W-1:0] idx;
    idx = addr[AW-1:SLC_SH] - base[AW-1:SLC_SH];
    return {dbase[AW-1:PG_SH], {PG_SH{1'b0}}} + {{(AW-SLC_W-2){1'b0}}, idx, 2'b00};
  endfunction

  function automatic logic [AW-1:0] f_pte_addr(input logic [VPN_W-1:0] tbl_pg,
                                               input logic [AW-1:0] addr);
    return {tbl_pg, addr[SLC_SH-1:PG_SH], 2'b00};
  endfunction

  function automatic logic [AW-1:0] f_join(input logic [VPN_W-1:0] ppn,
                                           input logic [AW-1:0] addr);
    return {ppn, addr[PG_SH-1:0]};
  endfunction
endpackage

// File: rtl/apt_cfg.sv
module apt_cfg
  import apt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [7:0]    addr,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] rdata,
  output logic [AW-1:0] dbase,
  output logic [AW-1:0] abase,
  output logic [2:0]    size_code,
  output logic          xlate_on,
  output logic          flush_evt
);
  logic [15:0]      ctl_q;
  logic [VPN_W-1:0] dbase_q;
  logic [SLC_W-1:0] abase_q;
  logic [3:0]       size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      dbase_q <= '0;
      abase_q <= '0;
      size_q  <= '0;
    end else if (we) begin
      case (addr)
        OFS_CTL:   ctl_q   <= wdata[15:0];
        OFS_DBASE: dbase_q <= wdata[AW-1:PG_SH];
        OFS_SIZE:  size_q  <= wdata[3:0];
        OFS_ABASE: abase_q <= wdata[AW-1:SLC_SH];
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_CTL:   rdata = {16'h0, ctl_q};
      OFS_DBASE: rdata = {dbase_q, {PG_SH{1'b0}}};
      OFS_SIZE:  rdata = {28'h0, size_q};
      OFS_ABASE: rdata = {abase_q, {SLC_SH{1'b0}}};
      default:   rdata = '0;
    endcase
  end

  assign dbase     = {dbase_q, {PG_SH{1'b0}}};
  assign abase     = {abase_q, {SLC_SH{1'b0}}};
  assign size_code = size_q[3:1];
  assign xlate_on  = ctl_q[CTL_EN_BIT] && size_q[0];
  assign flush_evt = we && (addr == OFS_FLUSH) && wdata[0];
endmodule

// File: rtl/apt_tlb.sv
module apt_tlb
  import apt_pkg::*;
#(
  parameter  int ENTRIES = 8,
  localparam int PTR_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [VPN_W-1:0]   lk_ppn,
  input  logic               ins_en,
  input  logic [VPN_W-1:0]   ins_vpn,
  input  logic [VPN_W-1:0]   ins_ppn,
  output logic [ENTRIES-1:0] vld_o,
  output logic [PTR_W-1:0]   rr_o
);
  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] match;
  logic [VPN_W-1:0]   tag [ENTRIES];
  logic [VPN_W-1:0]   ppn [ENTRIES];
  logic [PTR_W-1:0]   rr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign match[g] = vld[g] && (tag[g] == lk_vpn);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[g] <= 1'b0;
        tag[g] <= '0;
        ppn[g] <= '0;
      end else if (flush) begin
        vld[g] <= 1'b0;
      end else if (ins_en && (rr_q == PTR_W'(g))) begin
        vld[g] <= 1'b1;
        tag[g] <= ins_vpn;
        ppn[g] <= ins_ppn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) rr_q <= '0;
    else if (ins_en)     rr_q <= (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) lk_ppn = lk_ppn | ppn[i];
  end

  assign lk_hit = |match;
  assign vld_o  = vld;
  assign rr_o   = rr_q;
endmodule

// File: rtl/apt_walker.sv
module apt_walker
  import apt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  output logic             req_ready,
  input  logic             win_hit,
  input  logic             tlb_hit,
  input  logic [VPN_W-1:0] tlb_ppn,
  input  logic             flush,
  input  logic [AW-1:0]    dbase,
  input  logic [AW-1:0]    abase,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_err,
  output logic [AW-1:0]    rsp_addr,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [AW-1:0]    mem_rdata,
  output logic             ins_en,
  output logic [VPN_W-1:0] ins_vpn,
  output logic [VPN_W-1:0] ins_ppn
);
  walk_st_t         st_q;
  logic [AW-1:0]    va_q;
  logic [VPN_W-1:0] tbl_q;
  logic             accept, in_walk, abort, ent_ok;

  assign req_ready = (st_q == W_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_walk   = (st_q == W_DIR_REQ) || (st_q == W_DIR_WAIT) ||
                     (st_q == W_PTE_REQ) || (st_q == W_PTE_WAIT);
  assign abort     = flush && in_walk;
  assign ent_ok    = mem_rdata[0];

  assign mem_req  = (st_q == W_DIR_REQ) || (st_q == W_PTE_REQ);
  assign mem_addr = (st_q == W_PTE_REQ) ? f_pte_addr(tbl_q, va_q)
                                        : f_dir_addr(dbase, va_q, abase);

  assign ins_en  = (st_q == W_PTE_WAIT) && mem_rvalid && ent_ok && !flush;
  assign ins_vpn = va_q[AW-1:PG_SH];
  assign ins_ppn = mem_rdata[AW-1:PG_SH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= W_IDLE;
      va_q      <= '0;
      tbl_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st_q)
        W_IDLE: if (accept) begin
          if (!win_hit) begin
            rsp_valid <= 1'b1; rsp_hit <= 1'b0; rsp_err <= 1'b0;
            rsp_addr  <= req_addr;
          end else if (tlb_hit && !flush) begin
            rsp_valid <= 1'b1; rsp_hit <= 1'b1; rsp_err <= 1'b0;
            rsp_addr  <= f_join(tlb_ppn, req_addr);
          end else begin
            va_q <= req_addr;
            st_q <= W_DIR_REQ;
          end
        end
        W_DIR_REQ: st_q <= abort ? W_DRAIN : W_DIR_WAIT;
        W_DIR_WAIT: begin
          if (abort) st_q <= mem_rvalid ? W_DIR_REQ : W_DRAIN;
          else if (mem_rvalid) begin
            if (ent_ok) begin
              tbl_q <= mem_rdata[AW-1:PG_SH];
              st_q  <= W_PTE_REQ;
            end else begin
              rsp_valid <= 1'b1; rsp_hit <= 1'b1; rsp_err <= 1'b1;
              rsp_addr  <= '0;
              st_q      <= W_IDLE;
            end
          end
        end
        W_PTE_REQ: st_q <= abort ? W_DRAIN : W_PTE_WAIT;
        W_PTE_WAIT: begin
          if (abort) st_q <= mem_rvalid ? W_DIR_REQ : W_DRAIN;
          else if (mem_rvalid) begin
            rsp_valid <= 1'b1; rsp_hit <= 1'b1;
            rsp_err   <= !ent_ok;
            rsp_addr  <= ent_ok ? f_join(mem_rdata[AW-1:PG_SH], va_q) : '0;
            st_q      <= W_IDLE;
          end
        end
        W_DRAIN: if (mem_rvalid) st_q <= W_DIR_REQ;
        default: st_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/apt_xlate_top.sv
module apt_xlate_top
  import apt_pkg::*;
#(
  parameter  int CACHE_ENTRIES = 8,
  localparam int PTR_W = (CACHE_ENTRIES > 1) ? $clog2(CACHE_ENTRIES) : 1
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic        rsp_err,
  output logic [31:0] rsp_addr,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  logic [AW-1:0]            dbase, abase;
  logic [2:0]               size_code;
  logic                     xlate_on, flush_evt, win_hit;
  logic                     tlb_hit;
  logic [VPN_W-1:0]         tlb_ppn, ins_vpn, ins_ppn;
  logic                     install_evt, bypass_evt;
  logic [CACHE_ENTRIES-1:0] cache_vld;
  logic [PTR_W-1:0]         rr_ptr;

  apt_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .dbase(dbase), .abase(abase), .size_code(size_code),
    .xlate_on(xlate_on), .flush_evt(flush_evt)
  );

  assign win_hit    = xlate_on && f_in_window(req_addr, abase, size_code);
  assign bypass_evt = req_valid && req_ready && !win_hit;

  apt_tlb #(.ENTRIES(CACHE_ENTRIES)) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush_evt),
    .lk_vpn(req_addr[AW-1:PG_SH]), .lk_hit(tlb_hit), .lk_ppn(tlb_ppn),
    .ins_en(install_evt), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
    .vld_o(cache_vld), .rr_o(rr_ptr)
  );

  apt_walker u_walk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .win_hit(win_hit), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .flush(flush_evt), .dbase(dbase), .abase(abase),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err), .rsp_addr(rsp_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ins_en(install_evt), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn)
  );
endmodule

// File: rtl/apt_xlate_chk.sv
module apt_xlate_chk #(
  parameter  int ENTRIES = 8,
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
)(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [31:0]        req_addr,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_err,
  input logic [31:0]        rsp_addr,
  input logic               mem_req,
  input logic [31:0]        mem_addr,
  input logic               mem_rvalid,
  input logic [31:0]        mem_rdata,
  input logic               flush_evt,
  input logic               install_evt,
  input logic               bypass_evt,
  input logic [ENTRIES-1:0] cache_vld,
  input logic [PTR_W-1:0]   rr_ptr
);
  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_evt |=> rsp_valid && !rsp_hit && !rsp_err && rsp_addr == $past(req_addr)); // R3
  AST_ERR_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_hit && rsp_addr == 32'h0); // R5
  AST_INSTALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    install_evt |-> mem_rvalid && mem_rdata[0]); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> cache_vld == '0); // R8
  AST_NO_INSTALL_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    install_evt |-> !flush_evt); // R9
  AST_RR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    install_evt |=> rr_ptr == nxt($past(rr_ptr))); // R7
  AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00); // R4
  AST_SINGLE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R10
  AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !mem_rvalid || !req_ready); // R10
endmodule

bind apt_xlate_top apt_xlate_chk #(.ENTRIES(CACHE_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
  .rsp_addr(rsp_addr), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .flush_evt(flush_evt),
  .install_evt(install_evt), .bypass_evt(bypass_evt), .cache_vld(cache_vld),
  .rr_ptr(rr_ptr)
);

// File: tb/apt_xlate_top_tb_top.sv
`timescale 1ns/1ps
module apt_xlate_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = 32'h0;
  logic        rsp_valid, rsp_hit, rsp_err;
  logic [31:0] rsp_addr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = 32'h0;

  always #2 clk = ~clk;

  apt_xlate_top dut_i (.*);

  localparam logic [31:0] APB = 32'h4000_0000;
  localparam logic [31:0] DIRB = 32'h0010_0000;

  int checks = 0, fails = 0, rd_cnt = 0, mem_extra = 0;
  logic [31:0] rd_log [16];
  bit done = 0;
  logic [31:0] img [logic [31:0]];
  int win_mb = 32;
  bit on = 0;

  function automatic logic [31:0] mread(input logic [31:0] a);
    return img.exists(a) ? img[a] : 32'h0;
  endfunction

  function automatic logic [31:0] phys_of(input logic [31:0] va);
    return 32'h9000_0000 ^ (va & 32'h0FFF_F000);
  endfunction

  function automatic logic [31:0] pte_loc(input logic [31:0] va);
    logic [31:0] pde;
    pde = mread(DIRB + ((va >> 22) - (APB >> 22)) * 4);
    return (pde & 32'hFFFF_F000) + ((va >> 12) & 32'h3FF) * 4;
  endfunction

  task automatic map_page(input logic [31:0] va, input logic [31:0] ppa, input bit ok);
    img[pte_loc(va)] = (ppa & 32'hFFFF_F000) | (ok ? 32'h1 : 32'h0);
  endtask

  // expected result computed from the bench's own table image
  task automatic expect_of(input logic [31:0] va, output logic [31:0] ea,
                           output logic eh, output logic ee);
    logic [31:0] pde, pte;
    if (!on || va < APB || {1'b0, va} >= {1'b0, APB} + 33'(win_mb) * 33'h10_0000) begin
      ea = va; eh = 0; ee = 0;
    end else begin
      eh = 1;
      pde = mread(DIRB + ((va >> 22) - (APB >> 22)) * 4);
      pte = pde[0] ? mread(pte_loc(va)) : 32'h0;
      ee = !(pde[0] && pte[0]);
      ea = ee ? 32'h0 : ((pte & 32'hFFFF_F000) | (va & 32'hFFF));
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: snapshot at request, answer mem_extra+1 cycles later
  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        logic [31:0] d;
        if (rd_cnt < 16) rd_log[rd_cnt] = mem_addr;
        d = mread(mem_addr);
        rd_cnt++;
        repeat (mem_extra) @(negedge clk);
        @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = d;
      end
    end
  end

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic do_req(input logic [31:0] va, output logic [31:0] a, output logic h,
                        output logic e, output int lat, output int nrd, output logic rdy_mid);
    int c0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    c0 = rd_cnt;
    req_valid = 1; req_addr = va;
    @(negedge clk);
    req_valid = 0; lat = 1; rdy_mid = req_ready;
    while (!rsp_valid && lat < 300) begin @(negedge clk); lat++; end
    a = rsp_addr; h = rsp_hit; e = rsp_err; nrd = rd_cnt - c0;
  endtask

  task automatic req_check(input string tag, input logic [31:0] va, input int exp_rd);
    logic [31:0] a, ea; logic h, e, eh, ee, rm; int lat, nrd;
    expect_of(va, ea, eh, ee);
    do_req(va, a, h, e, lat, nrd, rm);
    chk({tag, " addr"}, a, ea);
    chk({tag, " hit"}, 32'(h), 32'(eh));
    chk({tag, " err"}, 32'(e), 32'(ee));
    if (exp_rd >= 0) chk({tag, " reads"}, nrd, exp_rd);
    if (exp_rd == 0) chk({tag, " one-cycle"}, lat, 1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R10 ready after reset", 32'(req_ready), 1);
    chk("R10 no read after reset", 32'(mem_req), 0);
    chk("R1 rsp_valid reset", 32'(rsp_valid), 0);
    cfg_read(8'h04, d); chk("R1 base reset", d, 0);
    cfg_read(8'h08, d); chk("R1 size reset", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    cfg_write(8'h02, 32'h0001_FFFF); cfg_read(8'h02, d); chk("R1 ctl readback", d, 32'hFFFF);
    cfg_write(8'h04, DIRB | 32'hABC); cfg_read(8'h04, d); chk("R1 dbase readback", d, DIRB);
    cfg_write(8'h10, 32'h4012_3456); cfg_read(8'h10, d); chk("R1 abase readback", d, APB);
    cfg_write(8'h08, 32'hFFFF_FFF3); cfg_read(8'h08, d); chk("R1 size readback", d, 32'h3);
    cfg_write(8'h0C, 32'h1); cfg_read(8'h0C, d); chk("R1 flush reads zero", d, 0);
    cfg_write(8'h02, 32'h0);
    cfg_write(8'h08, 32'h1);
  endtask

  task automatic t_disabled();
    on = 0;
    req_check("R2 ctl off", APB + 32'h1234, 0);
    cfg_write(8'h02, 32'h4); cfg_write(8'h08, 32'h0);
    req_check("R2 window bit off", APB + 32'h1234, 0);
    cfg_write(8'h08, 32'h1); on = 1; win_mb = 32;
  endtask

  task automatic t_walk();
    logic [31:0] a; logic h, e, rm; int lat, nrd;
    map_page(APB + 32'h1000, phys_of(APB + 32'h1000), 1);
    do_req(APB + 32'h1234, a, h, e, lat, nrd, rm);
    chk("R10 ready low in walk", 32'(rm), 0);
    chk("R4 translated", a, phys_of(APB + 32'h1000) | 32'h234);
    chk("R4 dir read addr", rd_log[rd_cnt - 2], DIRB);
    chk("R4 pte read addr", rd_log[rd_cnt - 1], 32'h0020_0004);
    req_check("R6 cache hit", APB + 32'h1FF8, 0);
  endtask

  task automatic t_window();
    map_page(32'h41FF_F000, phys_of(32'h41FF_F000), 1);
    req_check("R3 last page", 32'h41FF_F123, 2);
    req_check("R3 above top", 32'h4200_0000, 0);
    req_check("R3 below base", 32'h3FFF_FFFC, 0);
    cfg_write(8'h08, 32'h3); win_mb = 64;
    map_page(32'h4200_0000, phys_of(32'h4200_0000), 1);
    req_check("R3 64MiB slice 8", 32'h4200_0010, 2);
    cfg_write(8'h08, 32'hF); on = 0;
    req_check("R3 code 7 closed", APB + 32'h1234, 0);
    cfg_write(8'h08, 32'h3); on = 1;
  endtask

  task automatic t_invalid();
    map_page(APB + 32'h3000, 32'h0, 0);
    req_check("R5 invalid pte", APB + 32'h3010, 2);
    req_check("R5 invalid pte repeat walks", APB + 32'h3020, 2);
    req_check("R5 invalid pde", 32'h4240_0000, 1);
  endtask

  task automatic t_rr();
    cfg_write(8'h0C, 32'h1);
    for (int k = 0; k <= 8; k++) map_page(APB + k * 32'h1000, phys_of(APB + k * 32'h1000), 1);
    for (int k = 0; k <= 8; k++) req_check("R7 fill", APB + k * 32'h1000, 2);
    req_check("R7 oldest evicted", APB, 2);
    req_check("R7 survivor hits", APB + 32'h2000, 0);
    req_check("R7 second evicted", APB + 32'h1000, 2);
  endtask

  task automatic t_flush();
    cfg_write(8'h0C, 32'h0);
    req_check("R8 bit0 clear ignored", APB + 32'h3000, 0);
    cfg_write(8'h0C, 32'h1);
    req_check("R8 flush forces walk", APB + 32'h3000, 2);
  endtask

  task automatic t_flush_walk();
    logic [31:0] va; int c0, lat;
    va = APB + 32'h5000;
    cfg_write(8'h0C, 32'h1);
    mem_extra = 4;
    @(negedge clk);
    c0 = rd_cnt;
    req_valid = 1; req_addr = va + 32'h44;
    @(negedge clk);
    req_valid = 0;
    while (rd_cnt < c0 + 2) @(negedge clk);
    map_page(va, 32'h7777_7000, 1);
    cfg_write(8'h0C, 32'h1);
    lat = 0;
    while (!rsp_valid && lat < 300) begin @(negedge clk); lat++; end
    chk("R9 result uses new table", rsp_addr, 32'h7777_7044);
    chk("R9 walk restarted", rd_cnt - c0, 4);
    mem_extra = 0;
    req_check("R9 restarted walk cached", va + 32'h80, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 16; i++)
      img[DIRB + i * 4] = (i == 9) ? 32'h0 : (32'h0020_0000 + i * 32'h1000) | 32'h1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_disabled();
    t_walk();
    t_window();
    t_invalid();
    t_rr();
    t_flush();
    t_flush_walk();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule